// File: doc/BRIEF.md
# Redundant-Bus Remote Terminal Word Engine

This block is the message layer of a remote terminal on a dual redundant command/response serial bus. A word decoder in front of it hands over one 16-bit word at a time: which of the two buses it came from, whether it carried a command/status sync or a data sync, and whether its parity was bad. A separate pulse marks the idle gap that closes a message. The engine matches the command address against its programmed terminal address or the broadcast address 31. It collects the data words that follow and checks their count and parity. Only a clean message is committed to a buffer RAM. A reply is then produced, made of a status word and, for transmit commands, the requested data words. The reply goes one word at a time to a word encoder over a valid/ready pair.

The buffer RAM has 65 blocks of 32 words each. Block number `tr*32 + sa` holds the data for a command with transmit/receive bit `tr` and subaddress `sa`. Block 64 holds the data words of mode-code commands, one word per mode code. A host port reads and writes the RAM directly. Host pulses set and clear four status flags. Two options alter the data path and the flag behaviour. The wrap option makes transmit commands on subaddress 30 read the receive block of subaddress 30. The auto-busy option sets the busy flag after every accepted message.

Top module: `rt_responder`

## Requirements
- R1: A command-sync word with good parity is accepted when bits 15..11 equal `own_addr_i` (31 excluded) or when they equal 31 with bit 10 (transmit) low. Command words with other addresses, broadcast transmit commands and command words with bad parity produce no reply, no error and no change to the RAM.
- R2: For a receive command (bit 10 low) with subaddress bits 9..5 not 0 or 31, the word count is taken from bits 4..0, where 0 means 32. Exactly that many data words followed by the gap are written to RAM addresses `sa*32 + i` in arrival order. A status word is then sent.
- R3: A transmit command (bit 10 high) followed directly by the gap is answered with the status word and then `count` data words from RAM addresses `(32+sa)*32 + i`.
- R4: Subaddress 0 or 31 marks a mode code, held in bits 4..0. Codes 16..31 carry one data word. A receive mode code stores its word at address `2048 + code`, and a transmit mode code sends that word after the status word. Codes 0..15 are answered with the status word only.
- R5: With `wrap_en_i` high, a transmit command on subaddress 30 sends words from the receive block of subaddress 30, at addresses `960 + i`.
- R6: A valid broadcast receive message stores its data but is not answered. It sets the broadcast-received bit (bit 4), which appears in the next status word sent and is cleared once that word is taken.
- R7: Status word layout: bits 15..11 terminal address, bit 10 message error, bit 8 service request, bit 4 broadcast received, bit 3 busy, bit 2 subsystem flag, bit 0 terminal flag; bits 9, 7..5 and 1 are zero. The flag values used are those held when the message's gap arrives.
- R8: In `flag_set_i` and `flag_clr_i`, bit 0 is service request, bit 1 busy, bit 2 subsystem flag and bit 3 terminal flag. A set pulse makes the flag 1 and a clear pulse makes it 0. A set wins over a clear on the same bit in the same cycle.
- R9: With `autobusy_en_i` high, the busy flag becomes 1 after each accepted message. The status word of that message still shows the earlier busy value. Busy then stays set until a host clear.
- R10: A message whose data-word count differs from the count the command expects, or with a data word of bad parity, is discarded. This also applies to a message cut short by a new valid command word. A discarded message writes nothing to the RAM and gets no reply. `msg_err_o` pulses for one cycle, and bit 10 is set in the next status word sent, then cleared.
- R11: Data words from the bus other than the one that carried the command are ignored. Every word of a reply appears on `tx_bus_o` equal to the command's bus.
- R12: A reply word is held on `tx_word_o` with `tx_vld_o` high until `tx_rdy_i` is seen high. Only the first word of a reply has `tx_stat_o` high. After reset no word is presented.
- R13: The host port writes RAM word `host_addr_i` when `host_we_i` is high. `host_rdata_o` shows the word at the address presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 5 | Programmed terminal address |
| wrap_en_i | input | 1 | Subaddress-30 wrap option |
| autobusy_en_i | input | 1 | Auto-busy option |
| flag_set_i | input | 4 | Host set pulses for the status flags |
| flag_clr_i | input | 4 | Host clear pulses for the status flags |
| rx_vld_i | input | 1 | Decoded word present |
| rx_bus_i | input | 1 | Bus the word came from |
| rx_cmd_i | input | 1 | Word had command/status sync |
| rx_perr_i | input | 1 | Word had a parity error |
| rx_word_i | input | 16 | Decoded word |
| rx_gap_i | input | 1 | End-of-message gap pulse |
| tx_vld_o | output | 1 | Reply word present |
| tx_rdy_i | input | 1 | Encoder takes the reply word |
| tx_stat_o | output | 1 | Reply word needs status sync |
| tx_bus_o | output | 1 | Bus to send the reply on |
| tx_word_o | output | 16 | Reply word |
| msg_err_o | output | 1 | Discarded-message pulse |
| host_we_i | input | 1 | Host RAM write enable |
| host_addr_i | input | 12 | Host RAM word address |
| host_wdata_i | input | 16 | Host RAM write data |
| host_rdata_o | output | 16 | Host RAM read data |

## Verification
Random messages are drawn from several shapes: receive, transmit, mode code with and without data, broadcast, broadcast transmit, foreign address, short or long count, and data parity error. Wrap, auto-busy and the host flags are toggled between messages, and `tx_rdy_i` is random. Comparing each reply word for word against a model with the RAM preloaded at random separates the subaddress and direction mapping, the mode block and the wrap redirection. Comparing the expected status words tracks the broadcast, error and busy history across messages. Directed cases add data on the wrong bus mixed into a receive message, set-versus-clear on the same flag, wrap on and off for subaddress 30, and host readback of blocks the engine has written.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int SA_W      = 5;
  localparam int WC_W      = 5;
  localparam int IDX_W     = 5;
  localparam int NUM_FLAGS = 4;
  localparam int BLK_WORDS = 1 << IDX_W;
  localparam int CNT_W     = IDX_W + 1;
  localparam int BLK_IW    = SA_W + 2;
  localparam int MODE_BLK  = 2 << SA_W;
  localparam int RAM_DEPTH = (MODE_BLK + 1) * BLK_WORDS;
  localparam int RAM_AW    = BLK_IW + IDX_W;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;
  localparam logic [SA_W-1:0]   WRAP_SA    = SA_W'(30);
  localparam logic [SA_W-1:0]   MODE_SA_LO = '0;
  localparam logic [SA_W-1:0]   MODE_SA_HI = '1;

  // host flag bit positions
  localparam int FL_SR   = 0;
  localparam int FL_BUSY = 1;
  localparam int FL_SSF  = 2;
  localparam int FL_TF   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_COMMIT, ST_TXST, ST_TXRD, ST_TXDAT
  } rt_state_e;

  typedef struct packed {
    logic             bcast;
    logic             mode;
    logic             tr;
    logic             bus;
    logic [SA_W-1:0]  sa;
    logic [WC_W-1:0]  code;
    logic [CNT_W-1:0] cnt;
  } msg_t;
endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
  import rt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              match_o,
  output logic              bcast_o,
  output logic              mode_o,
  output logic              tr_o,
  output logic [SA_W-1:0]   sa_o,
  output logic [WC_W-1:0]   code_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [ADDR_W-1:0] adr;

  always_comb begin
    adr     = word_i[WORD_W-1 -: ADDR_W];
    tr_o    = word_i[WC_W + SA_W];
    sa_o    = word_i[WC_W +: SA_W];
    code_o  = word_i[WC_W-1:0];
    bcast_o = (adr == BCAST_ADDR);
    mode_o  = (sa_o == MODE_SA_LO) || (sa_o == MODE_SA_HI);
    match_o = ((adr == own_addr_i) && !bcast_o) || (bcast_o && !tr_o);
    if (mode_o)
      cnt_o = code_o[WC_W-1] ? CNT_W'(1) : '0;
    else if (code_o == '0)
      cnt_o = CNT_W'(BLK_WORDS);
    else
      cnt_o = CNT_W'(code_o);
  end
endmodule

// File: rtl/rt_status_flags.sv
module rt_status_flags
  import rt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] host_set_i,
  input  logic [NUM_FLAGS-1:0] host_clr_i,
  input  logic                 autobusy_en_i,
  input  logic                 done_i,
  input  logic                 bcast_done_i,
  input  logic                 err_i,
  input  logic                 take_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 me_o,
  output logic                 bcr_o
);
  logic [NUM_FLAGS-1:0] hf_q, hf_d;
  logic                 me_q, me_d, bcr_q, bcr_d, flag_en;

  always_comb begin
    hf_d = (hf_q & ~host_clr_i) | host_set_i;
    if (autobusy_en_i && done_i) hf_d[FL_BUSY] = 1'b1;
    me_d = me_q;
    if (take_i) me_d = 1'b0;
    if (err_i)  me_d = 1'b1;
    bcr_d = bcr_q;
    if (take_i)       bcr_d = 1'b0;
    if (bcast_done_i) bcr_d = 1'b1;
    flag_en = (|host_set_i) | (|host_clr_i) | done_i | err_i | take_i | bcast_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_q  <= '0;
      me_q  <= 1'b0;
      bcr_q <= 1'b0;
    end else if (flag_en) begin
      hf_q  <= hf_d;
      me_q  <= me_d;
      bcr_q <= bcr_d;
    end
  end

  assign flags_o = hf_q;
  assign me_o    = me_q;
  assign bcr_o   = bcr_q;

  // R8
  host_set_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_set_i[FL_BUSY] |=> flags_o[FL_BUSY]);
  // R9
  autobusy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autobusy_en_i && done_i) |=> flags_o[FL_BUSY]);
  // R10
  err_sets_me_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> me_o);
  // R6
  take_clears_bcr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !bcast_done_i) |=> !bcr_o);
endmodule

// File: rtl/rt_buffer_ram.sv
module rt_buffer_ram
  import rt_pkg::*;
(
  input  logic              clk,
  input  logic              eng_we_i,
  input  logic              eng_re_i,
  input  logic [RAM_AW-1:0] eng_addr_i,
  input  logic [WORD_W-1:0] eng_wdata_i,
  output logic [WORD_W-1:0] eng_rdata_o,
  input  logic              host_we_i,
  input  logic [RAM_AW-1:0] host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o
);
  logic [WORD_W-1:0] mem [RAM_DEPTH];
  logic              eng_ok, host_ok;

  assign eng_ok  = (int'(eng_addr_i)  < RAM_DEPTH);
  assign host_ok = (int'(host_addr_i) < RAM_DEPTH);

  // engine write has priority over a host write in the same cycle
  always_ff @(posedge clk) begin
    if (eng_we_i && eng_ok)
      mem[eng_addr_i] <= eng_wdata_i;
    else if (host_we_i && host_ok)
      mem[host_addr_i] <= host_wdata_i;
  end

  always_ff @(posedge clk) begin
    if (eng_re_i)
      eng_rdata_o <= eng_ok ? mem[eng_addr_i] : '0;
    host_rdata_o <= host_ok ? mem[host_addr_i] : '0;
  end
endmodule

// File: rtl/rt_responder.sv
module rt_responder
  import rt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    own_addr_i,
  input  logic                 wrap_en_i,
  input  logic                 autobusy_en_i,
  input  logic [NUM_FLAGS-1:0] flag_set_i,
  input  logic [NUM_FLAGS-1:0] flag_clr_i,
  input  logic                 rx_vld_i,
  input  logic                 rx_bus_i,
  input  logic                 rx_cmd_i,
  input  logic                 rx_perr_i,
  input  logic [WORD_W-1:0]    rx_word_i,
  input  logic                 rx_gap_i,
  output logic                 tx_vld_o,
  input  logic                 tx_rdy_i,
  output logic                 tx_stat_o,
  output logic                 tx_bus_o,
  output logic [WORD_W-1:0]    tx_word_o,
  output logic                 msg_err_o,
  input  logic                 host_we_i,
  input  logic [RAM_AW-1:0]    host_addr_i,
  input  logic [WORD_W-1:0]    host_wdata_i,
  output logic [WORD_W-1:0]    host_rdata_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // command decode
  logic             dec_match, dec_bcast, dec_mode, dec_tr;
  logic [SA_W-1:0]  dec_sa;
  logic [WC_W-1:0]  dec_code;
  logic [CNT_W-1:0] dec_cnt;

  rt_cmd_decode u_dec (
    .word_i(rx_word_i), .own_addr_i(own_addr_i),
    .match_o(dec_match), .bcast_o(dec_bcast), .mode_o(dec_mode), .tr_o(dec_tr),
    .sa_o(dec_sa), .code_o(dec_code), .cnt_o(dec_cnt)
  );

  // state
  rt_state_e        state_q, state_d;
  msg_t             cur_q, cur_d;
  logic [CNT_W-1:0] got_q, got_d, idx_q, idx_d;
  logic             bad_q, bad_d;
  logic [WORD_W-1:0] stat_q, stat_d;
  logic             err_q;
  logic [WORD_W-1:0] stage_q [BLK_WORDS];

  // flag block
  logic [NUM_FLAGS-1:0] flags;
  logic me, bcr, ev_err, ev_done, ev_bdone, ev_take;

  rt_status_flags u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .host_set_i(flag_set_i), .host_clr_i(flag_clr_i),
    .autobusy_en_i(autobusy_en_i),
    .done_i(ev_done), .bcast_done_i(ev_bdone), .err_i(ev_err), .take_i(ev_take),
    .flags_o(flags), .me_o(me), .bcr_o(bcr)
  );

  // RAM
  logic              ram_we, ram_re;
  logic [RAM_AW-1:0] ram_addr;
  logic [WORD_W-1:0] ram_rdata;

  rt_buffer_ram u_ram (
    .clk(clk),
    .eng_we_i(ram_we), .eng_re_i(ram_re), .eng_addr_i(ram_addr),
    .eng_wdata_i(stage_q[idx_q[IDX_W-1:0]]), .eng_rdata_o(ram_rdata),
    .host_we_i(host_we_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o)
  );

  // derived
  logic              cmd_ok, data_in, stage_we, last_ix, seq_en;
  logic [CNT_W-1:0]  rx_need;
  logic [IDX_W-1:0]  word_ix;
  logic [BLK_IW-1:0] blk_rx, blk_tx;
  logic [WORD_W-1:0] stat_word;
  msg_t              dec_msg;

  always_comb begin
    cmd_ok  = rx_vld_i && rx_cmd_i && !rx_perr_i;
    data_in = rx_vld_i && !rx_cmd_i && (rx_bus_i == cur_q.bus);
    rx_need = cur_q.tr ? '0 : cur_q.cnt;
    last_ix = (idx_q + CNT_W'(1)) == cur_q.cnt;
    word_ix = cur_q.mode ? cur_q.code : idx_q[IDX_W-1:0];
    blk_rx  = cur_q.mode ? BLK_IW'(MODE_BLK) : {2'b00, cur_q.sa};
    if (cur_q.mode)
      blk_tx = BLK_IW'(MODE_BLK);
    else if (wrap_en_i && (cur_q.sa == WRAP_SA))
      blk_tx = {2'b00, cur_q.sa};
    else
      blk_tx = {2'b01, cur_q.sa};
    ram_addr  = (state_q == ST_COMMIT) ? {blk_rx, word_ix} : {blk_tx, word_ix};
    stat_word = {own_addr_i, me, 1'b0, flags[FL_SR], 3'b000,
                 bcr, flags[FL_BUSY], flags[FL_SSF], 1'b0, flags[FL_TF]};
    dec_msg   = '{bcast: dec_bcast, mode: dec_mode, tr: dec_tr, bus: rx_bus_i,
                  sa: dec_sa, code: dec_code, cnt: dec_cnt};
    seq_en    = rx_vld_i || rx_gap_i || (state_q != ST_IDLE);
  end

  // next state
  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    got_d    = got_q;
    idx_d    = idx_q;
    bad_d    = bad_q;
    stat_d   = stat_q;
    ev_err   = 1'b0;
    ev_done  = 1'b0;
    ev_bdone = 1'b0;
    ev_take  = 1'b0;
    stage_we = 1'b0;
    ram_we   = 1'b0;
    ram_re   = 1'b0;
    tx_vld_o = 1'b0;
    tx_stat_o = 1'b0;
    tx_word_o = ram_rdata;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_ok && dec_match) begin
          cur_d   = dec_msg;
          got_d   = '0;
          bad_d   = 1'b0;
          state_d = ST_RX;
        end
      end
      ST_RX: begin
        if (cmd_ok) begin
          ev_err = 1'b1;
          if (dec_match) begin
            cur_d = dec_msg;
            got_d = '0;
            bad_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (data_in) begin
          if (rx_perr_i) bad_d = 1'b1;
          if (got_q < rx_need) stage_we = 1'b1;
          if (got_q <= rx_need) got_d = got_q + CNT_W'(1);
        end else if (rx_gap_i) begin
          if (bad_q || (got_q != rx_need)) begin
            ev_err  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ev_done = 1'b1;
            idx_d   = '0;
            if (cur_q.bcast) ev_bdone = 1'b1;
            else begin
              ev_take = 1'b1;
              stat_d  = stat_word;
            end
            if (rx_need != '0)     state_d = ST_COMMIT;
            else if (!cur_q.bcast) state_d = ST_TXST;
            else                   state_d = ST_IDLE;
          end
        end
      end
      ST_COMMIT: begin
        ram_we = 1'b1;
        idx_d  = idx_q + CNT_W'(1);
        if (last_ix) state_d = cur_q.bcast ? ST_IDLE : ST_TXST;
      end
      ST_TXST: begin
        tx_vld_o  = 1'b1;
        tx_stat_o = 1'b1;
        tx_word_o = stat_q;
        if (tx_rdy_i) begin
          idx_d   = '0;
          state_d = (cur_q.tr && (cur_q.cnt != '0)) ? ST_TXRD : ST_IDLE;
        end
      end
      ST_TXRD: begin
        ram_re  = 1'b1;
        state_d = ST_TXDAT;
      end
      ST_TXDAT: begin
        tx_vld_o = 1'b1;
        if (tx_rdy_i) begin
          idx_d   = idx_q + CNT_W'(1);
          state_d = last_ix ? ST_IDLE : ST_TXRD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      got_q   <= '0;
      idx_q   <= '0;
      bad_q   <= 1'b0;
      stat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= ev_err;
      if (seq_en) begin
        state_q <= state_d;
        cur_q   <= cur_d;
        got_q   <= got_d;
        idx_q   <= idx_d;
        bad_q   <= bad_d;
        stat_q  <= stat_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stage_we) stage_q[got_q[IDX_W-1:0]] <= rx_word_i;
  end

  assign tx_bus_o  = cur_q.bus;
  assign msg_err_o = err_q;

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_vld_o && !tx_rdy_i) |=> (tx_vld_o && $stable(tx_word_o)));
  // R10
  err_no_reply_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msg_err_o |-> !tx_vld_o);
  // R6
  bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_vld_o |-> !cur_q.bcast);
  // R11
  reply_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_vld_o && $past(tx_vld_o)) |-> $stable(tx_bus_o));
endmodule

// File: tb/rt_responder_bench.sv
module rt_responder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2080;
  localparam logic [4:0] OWN = 5'd9;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]  own_addr;
  logic        wrap_en, autobusy_en;
  logic [3:0]  flag_set, flag_clr;
  logic        rx_vld, rx_bus, rx_cmd, rx_perr, rx_gap;
  logic [15:0] rx_word;
  logic        tx_vld, tx_rdy, tx_stat, tx_bus, msg_err;
  logic [15:0] tx_word;
  logic        host_we;
  logic [11:0] host_addr;
  logic [15:0] host_wdata, host_rdata;

  rt_responder u_rt_responder (
    .clk(clk), .rst_n(rst_n), .own_addr_i(own_addr), .wrap_en_i(wrap_en),
    .autobusy_en_i(autobusy_en), .flag_set_i(flag_set), .flag_clr_i(flag_clr),
    .rx_vld_i(rx_vld), .rx_bus_i(rx_bus), .rx_cmd_i(rx_cmd), .rx_perr_i(rx_perr),
    .rx_word_i(rx_word), .rx_gap_i(rx_gap),
    .tx_vld_o(tx_vld), .tx_rdy_i(tx_rdy), .tx_stat_o(tx_stat), .tx_bus_o(tx_bus),
    .tx_word_o(tx_word), .msg_err_o(msg_err),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] mdl_mem [DEPTH];
  logic m_sr, m_busy, m_ssf, m_tf, m_me, m_bcr;
  logic [15:0] msg_d [32];
  logic [15:0] exp_w [40];
  int exp_n, exp_err;
  logic [15:0] rep_w [40];
  logic rep_s [40];
  logic rep_b [40];
  int rep_n = 0, err_seen = 0;
  bit collect = 0, rdy_all = 1;

  always @(posedge clk) tx_rdy <= rdy_all ? 1'b1 : 1'($urandom_range(0, 1));

  always @(negedge clk) begin
    if (collect && tx_vld && tx_rdy) begin
      if (rep_n < 40) begin
        rep_w[rep_n] = tx_word;
        rep_s[rep_n] = tx_stat;
        rep_b[rep_n] = tx_bus;
      end
      rep_n++;
    end
    if (msg_err) err_seen++;
  end

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] mstat();
    return {OWN, m_me, 1'b0, m_sr, 3'b000, m_bcr, m_busy, m_ssf, 1'b0, m_tf};
  endfunction

  task automatic put(bit bus, bit cmd, bit perr, logic [15:0] w);
    @(negedge clk);
    rx_vld = 1; rx_bus = bus; rx_cmd = cmd; rx_perr = perr; rx_word = w;
  endtask

  task automatic hwrite(int a, logic [15:0] d);
    @(negedge clk);
    host_we = 1; host_addr = 12'(a); host_wdata = d;
    @(negedge clk);
    host_we = 0;
    mdl_mem[a] = d;
  endtask

  task automatic hread_chk(int a, string req);
    @(negedge clk);
    host_addr = 12'(a);
    @(negedge clk);
    chk(host_rdata === mdl_mem[a], req, "host readback", int'(host_rdata), int'(mdl_mem[a]));
  endtask

  task automatic hflags(logic [3:0] s, logic [3:0] c);
    @(negedge clk);
    flag_set = s; flag_clr = c;
    @(negedge clk);
    flag_set = 0; flag_clr = 0;
    {m_tf, m_ssf, m_busy, m_sr} = ({m_tf, m_ssf, m_busy, m_sr} & ~c) | s;
  endtask

  // model of one message: fills exp_* and updates model state
  task automatic model_msg(logic [15:0] cw, int nd, bit bad);
    logic [4:0] a, sa, wc;
    bit tr, mode, bc, hit;
    int cnt, need, base;
    a = cw[15:11]; tr = cw[10]; sa = cw[9:5]; wc = cw[4:0];
    mode = (sa == 0) || (sa == 31);
    cnt = mode ? (wc[4] ? 1 : 0) : (wc == 0 ? 32 : int'(wc));
    bc = (a == 5'd31);
    hit = ((a == OWN) && !bc) || (bc && !tr);
    exp_n = 0; exp_err = 0;
    if (!hit) return;
    need = tr ? 0 : cnt;
    if (bad || nd != need) begin
      exp_err = 1; m_me = 1;
      return;
    end
    if (!tr)
      for (int i = 0; i < cnt; i++)
        mdl_mem[mode ? 2048 + int'(wc) : int'(sa) * 32 + i] = msg_d[i];
    if (!bc) begin
      exp_w[0] = mstat(); exp_n = 1; m_me = 0; m_bcr = 0;
      if (tr) begin
        base = (wrap_en && sa == 30) ? int'(sa) * 32 : (32 + int'(sa)) * 32;
        for (int i = 0; i < cnt; i++) begin
          exp_w[exp_n] = mdl_mem[mode ? 2048 + int'(wc) : base + i];
          exp_n++;
        end
      end
    end else m_bcr = 1;
    if (autobusy_en) m_busy = 1;
  endtask

  task automatic run_msg(bit bus, logic [15:0] cw, int nd, int perr_at, bit noise, string req);
    int e0;
    model_msg(cw, nd, perr_at >= 0 && perr_at < nd);
    rep_n = 0; e0 = err_seen; collect = 1;
    put(bus, 1, 0, cw);
    for (int i = 0; i < nd; i++) begin
      if (noise) put(!bus, 0, 0, 16'hA5A5);
      put(bus, 0, i == perr_at, msg_d[i]);
    end
    @(negedge clk); rx_vld = 0; rx_gap = 1;
    @(negedge clk); rx_gap = 0;
    repeat (300) @(negedge clk);
    collect = 0;
    chk(rep_n == exp_n, req, "reply length", rep_n, exp_n);
    for (int i = 0; i < exp_n && i < rep_n; i++) begin
      chk(rep_w[i] === exp_w[i], req, $sformatf("reply word %0d", i), int'(rep_w[i]), int'(exp_w[i]));
      chk(rep_s[i] == (i == 0), "R12", "status sync marker", int'(rep_s[i]), int'(i == 0));
      chk(rep_b[i] == bus, "R11", "reply bus", int'(rep_b[i]), int'(bus));
    end
    chk(err_seen - e0 == exp_err, "R10", "error pulses", err_seen - e0, exp_err);
  endtask

  function automatic logic [15:0] mkcmd(logic [4:0] a, bit tr, logic [4:0] sa, logic [4:0] wc);
    return {a, tr, sa, wc};
  endfunction

  task automatic fill_d();
    for (int i = 0; i < 32; i++) msg_d[i] = 16'($urandom);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; own_addr = OWN; wrap_en = 0; autobusy_en = 0;
    flag_set = 0; flag_clr = 0; rx_vld = 0; rx_bus = 0; rx_cmd = 0; rx_perr = 0;
    rx_word = 0; rx_gap = 0; host_we = 0; host_addr = 0; host_wdata = 0;
    {m_sr, m_busy, m_ssf, m_tf, m_me, m_bcr} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(tx_vld == 0, "R12", "tx_vld after reset", int'(tx_vld), 0);
    chk(msg_err == 0, "R10", "msg_err after reset", int'(msg_err), 0);

    // R13: preload the whole RAM through the host port
    for (int a = 0; a < DEPTH; a++) hwrite(a, 16'($urandom));
    hread_chk(5, "R13");
    hread_chk(2079, "R13");

    // R7/R8: flags, set wins over clear
    hflags(4'b1101, 4'b0000);
    hflags(4'b0010, 4'b0011);
    fill_d();
    run_msg(0, mkcmd(OWN, 1, 5'd0, 5'd3), 0, -1, 0, "R7");
    hflags(4'b0000, 4'b1111);

    // R2 and R11: receive with noise on the other bus, then readback
    fill_d();
    run_msg(1, mkcmd(OWN, 0, 5'd7, 5'd4), 4, -1, 1, "R2");
    for (int i = 0; i < 4; i++) hread_chk(7 * 32 + i, "R2");

    // R3 transmit full block (count 0 = 32)
    rdy_all = 0;
    run_msg(0, mkcmd(OWN, 1, 5'd12, 5'd0), 0, -1, 0, "R3");

    // R4 mode code with data, then transmit it back
    fill_d();
    run_msg(0, mkcmd(OWN, 0, 5'd31, 5'd20), 1, -1, 0, "R4");
    hread_chk(2048 + 20, "R4");
    run_msg(1, mkcmd(OWN, 1, 5'd0, 5'd20), 0, -1, 0, "R4");
    run_msg(1, mkcmd(OWN, 1, 5'd0, 5'd2), 0, -1, 0, "R4");

    // R5 wrap on and off
    fill_d();
    run_msg(0, mkcmd(OWN, 0, 5'd30, 5'd5), 5, -1, 0, "R5");
    wrap_en = 1;
    run_msg(0, mkcmd(OWN, 1, 5'd30, 5'd5), 0, -1, 0, "R5");
    wrap_en = 0;
    run_msg(0, mkcmd(OWN, 1, 5'd30, 5'd5), 0, -1, 0, "R5");

    // R6 broadcast then status shows bit 4
    fill_d();
    run_msg(0, mkcmd(5'd31, 0, 5'd3, 5'd2), 2, -1, 0, "R6");
    hread_chk(3 * 32 + 1, "R6");
    run_msg(0, mkcmd(OWN, 1, 5'd0, 5'd1), 0, -1, 0, "R6");

    // R10 short count, parity error, then status shows bit 10
    fill_d();
    run_msg(0, mkcmd(OWN, 0, 5'd9, 5'd6), 5, -1, 0, "R10");
    run_msg(0, mkcmd(OWN, 0, 5'd9, 5'd6), 6, 2, 0, "R10");
    hread_chk(9 * 32 + 2, "R10");
    run_msg(0, mkcmd(OWN, 1, 5'd0, 5'd1), 0, -1, 0, "R10");

    // R9 autobusy
    autobusy_en = 1;
    run_msg(0, mkcmd(OWN, 1, 5'd0, 5'd1), 0, -1, 0, "R9");
    run_msg(0, mkcmd(OWN, 1, 5'd0, 5'd1), 0, -1, 0, "R9");
    hflags(4'b0000, 4'b0010);
    autobusy_en = 0;

    // R1 foreign address, broadcast transmit, bad-parity command
    run_msg(0, mkcmd(5'd4, 0, 5'd2, 5'd1), 1, -1, 0, "R1");
    run_msg(0, mkcmd(5'd31, 1, 5'd2, 5'd1), 0, -1, 0, "R1");
    hread_chk(2 * 32, "R1");

    // random mix
    for (int m = 0; m < 60; m++) begin
      int kind, nd, pa;
      logic [4:0] sa, wc, a;
      bit tr, mode;
      int cnt;
      string req;
      fill_d();
      wrap_en = 1'($urandom_range(0, 1));
      autobusy_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) hflags(4'($urandom), 4'($urandom));
      kind = $urandom_range(0, 6);
      a = OWN; tr = 0; sa = 5'($urandom_range(1, 30)); wc = 5'($urandom);
      pa = -1; req = "R2";
      case (kind)
        1: begin tr = 1; req = "R3"; end
        2: begin sa = $urandom_range(0, 1) ? 5'd0 : 5'd31; tr = 1'($urandom_range(0, 1)); req = "R4"; end
        3: begin a = 5'd31; if ($urandom_range(0, 1) == 1) sa = 5'd0; req = "R6"; end
        4: begin a = 5'($urandom_range(0, 30)); if (a == OWN) a = 5'd1; req = "R1"; end
        6: begin a = 5'd31; tr = 1; req = "R1"; end
        default: ;
      endcase
      if (sa == 30 && tr) req = "R5";
      mode = (sa == 0) || (sa == 31);
      cnt = mode ? (wc[4] ? 1 : 0) : (wc == 0 ? 32 : int'(wc));
      nd = tr ? 0 : cnt;
      if (kind == 5) begin
        req = "R10";
        if ($urandom_range(0, 1) == 1 && nd > 0) pa = $urandom_range(0, nd - 1);
        else nd = (nd > 0) ? nd - 1 : 1;
      end
      run_msg(1'($urandom_range(0, 1)), mkcmd(a, tr, sa, wc), nd, pa, 1'($urandom_range(0, 1)), req);
    end
    summary();
  end
endmodule